// File: doc/BRIEF.md
# Segmented Firmware Image Loader

The loader takes a firmware image as a stream of 32-bit words, one word per accepted valid/ready transfer, together with the image length in bytes. It walks the image as a chain of records. Each record is a 16-byte header followed by a payload. A header carries two marker words, a target load address and a payload size. A record whose markers match is a segment: its payload is copied word by word into a target memory at the load address. A record whose markers do not match is stepped over by its size field.

Every stored word is read back and compared before the next word is taken. The memory is reached through a window of `PAGE_BYTES` bytes. A page-select output gives the window base, and the memory address output gives the byte offset inside the window. The physical location of an access is therefore `pageSel + memAddr`. The loader also reports the load address of the first segment it meets, and a sticky done flag. On a failed compare it reports a sticky error flag and the image byte offset of the failing word. After a clean run it reports the image size.

Top module: `fw_seg_loader`

## Requirements
- R1: A header is four words in stream order: marker A, marker B, load address, payload size in bytes (a multiple of 4). It is a segment only when marker A is 0x6D676553 and marker B is 0x72646548. The payload words of a segment are written in order to locations load address, load address + 4, and so on.
- R2: When the markers do not match, the following size bytes are consumed from the stream and nothing is written to memory. The next header is expected right after them.
- R3: `entryAddr` takes the load address of the first segment after a start. Later segments do not change it.
- R4: If a segment's header offset + 16 + size exceeds the image length, loading ends at once. No payload word of that segment is written, and the run completes without error.
- R5: Before the first word of each `PAGE_BYTES` chunk of a segment is written, `pageSel` equals the load address plus the chunk's byte offset. `memAddr` is the byte offset of the word inside its chunk.
- R6: Each write is followed in the next cycle by a read of the same location, and the data is compared one cycle later. On a mismatch the run halts with `error` set, `errOffset` set to the image byte offset of the failing word, and `pageSel` returned to 0.
- R7: A new header is parsed only while the current image offset + 16 is strictly less than the image length.
- R8: When a run ends, `pageSel` is 0 and `done` is set. `loadedBytes` equals the image length after a clean run and is 0 after an error.
- R9: `done` and `error` stay set until the next `start`. A `start` clears both, along with `entryAddr`, `errOffset` and `loadedBytes`.
- R10: After reset, `done`, `error`, `inReady`, `memWe`, `memRe` and `pageSel` are all 0.
- R11: A stream word is consumed only in a cycle where both `inValid` and `inReady` are high. Gaps in `inValid` do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load when idle |
| imageBytes | input | LEN_W | Image length in bytes, sampled at start |
| inValid | input | 1 | Stream word is present |
| inData | input | 32 | Stream word |
| inReady | output | 1 | Loader accepts the stream word |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe; data is returned one cycle later |
| memAddr | output | PAGE_W | Byte offset inside the page window |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| pageSel | output | 32 | Base byte address of the page window |
| done | output | 1 | Sticky end-of-run flag |
| error | output | 1 | Sticky read-back mismatch flag |
| errOffset | output | LEN_W | Image byte offset of the failing word |
| entryAddr | output | 32 | Load address of the first segment |
| loadedBytes | output | LEN_W | Image size after a clean run |

## Verification
Each word costs three cycles: the accept and write, the read in the next cycle, and the compare in the cycle after that. The run then ends one cycle after the last compare or the last failed loop test, when `done` rises. The bench therefore never samples at a fixed offset from `start`. It polls `done` on falling clock edges and checks every status output only after `done` is seen. Memory contents, the write count and the page bases logged at chunk starts are captured by the bench's memory model on rising edges, which lets them be compared after completion. The number of stream words consumed is checked the same way, to confirm that skipped and overrun records stop or continue the stream exactly as required.

// File: rtl/fw_seg_loader_pkg.sv
package fw_seg_loader_pkg;

  localparam logic [31:0] MARK_A = 32'h6D676553;
  localparam logic [31:0] MARK_B = 32'h72646548;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PARSE, ST_HDR, ST_CHECK, ST_SKIP, ST_WR, ST_RD, ST_CMP, ST_FIN
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic hdrTake;
    logic offAdd4;
    logic offAddSize;
    logic jClr;
    logic jAdd4;
    logic entryTake;
    logic pageFirst;
    logic pageNext;
    logic wordLatch;
    logic memWrite;
    logic memRead;
    logic flagErr;
    logic finish;
  } loadCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic haveRoom;
    logic syncOk;
    logic overrun;
    logic sizeZero;
    logic skipDone;
    logic lastWord;
    logic nextChunk;
    logic mismatch;
    logic hdrLast;
  } loadFlags_t;

endpackage

// File: rtl/fw_seg_loader_ctrl.sv
module fw_seg_loader_ctrl
  import fw_seg_loader_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  loadFlags_t flags,
  output logic       inReady,
  output loadCtrl_t  ctrl
);

  loadState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    ctrl    = '0;
    inReady = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctrl.clrAll = 1'b1;
          stateD      = ST_PARSE;
        end
      end
      ST_PARSE: stateD = flags.haveRoom ? ST_HDR : ST_FIN;
      ST_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.hdrTake = 1'b1;
          ctrl.offAdd4 = 1'b1;
          if (flags.hdrLast) stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        ctrl.jClr = 1'b1;
        if (!flags.syncOk) begin
          stateD = ST_SKIP;
        end else begin
          ctrl.entryTake = 1'b1;
          if (flags.overrun)       stateD = ST_FIN;
          else if (flags.sizeZero) stateD = ST_PARSE;
          else begin
            ctrl.pageFirst = 1'b1;
            stateD         = ST_WR;
          end
        end
      end
      ST_SKIP: begin
        if (flags.skipDone) begin
          stateD = ST_PARSE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            ctrl.offAdd4 = 1'b1;
            ctrl.jAdd4   = 1'b1;
          end
        end
      end
      ST_WR: begin
        inReady = 1'b1;
        if (inValid) begin
          ctrl.memWrite  = 1'b1;
          ctrl.wordLatch = 1'b1;
          stateD         = ST_RD;
        end
      end
      ST_RD: begin
        ctrl.memRead = 1'b1;
        stateD       = ST_CMP;
      end
      ST_CMP: begin
        if (flags.mismatch) begin
          ctrl.flagErr = 1'b1;
          stateD       = ST_FIN;
        end else if (flags.lastWord) begin
          ctrl.offAddSize = 1'b1;
          stateD          = ST_PARSE;
        end else begin
          ctrl.jAdd4    = 1'b1;
          ctrl.pageNext = flags.nextChunk;
          stateD        = ST_WR;
        end
      end
      ST_FIN: begin
        ctrl.finish = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R11
  no_take_without_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.hdrTake || ctrl.memWrite) |-> (inReady && inValid));

endmodule

// File: rtl/fw_seg_loader_dp.sv
module fw_seg_loader_dp
  import fw_seg_loader_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int PAGE_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadCtrl_t         ctrl,
  input  logic [LEN_W-1:0]  imageBytes,
  input  logic [31:0]       inData,
  input  logic [31:0]       memRdata,
  output loadFlags_t        flags,
  output logic              memWe,
  output logic              memRe,
  output logic [PAGE_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       pageSel,
  output logic              done,
  output logic              error,
  output logic [LEN_W-1:0]  errOffset,
  output logic [31:0]       entryAddr,
  output logic [LEN_W-1:0]  loadedBytes
);

  localparam int SUM_W = 34;

  logic [LEN_W-1:0] offsetQ, lenQ, errOffQ, loadedQ;
  logic [1:0]       hdrIdxQ;
  logic [31:0]      markAQ, markBQ, addrQ, sizeQ, jQ, wordQ, pageQ, entryQ;
  logic             entrySetQ, doneQ, errQ;
  logic [31:0]      jNext;

  assign jNext = jQ + 32'd4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0; lenQ <= '0; errOffQ <= '0; loadedQ <= '0;
      hdrIdxQ <= '0; markAQ <= '0; markBQ <= '0; addrQ <= '0; sizeQ <= '0;
      jQ <= '0; wordQ <= '0; pageQ <= '0; entryQ <= '0;
      entrySetQ <= 1'b0; doneQ <= 1'b0; errQ <= 1'b0;
    end else begin
      if (ctrl.clrAll) begin
        offsetQ <= '0; lenQ <= imageBytes; errOffQ <= '0; loadedQ <= '0;
        hdrIdxQ <= '0; jQ <= '0; entryQ <= '0;
        entrySetQ <= 1'b0; doneQ <= 1'b0; errQ <= 1'b0;
      end
      if (ctrl.hdrTake) begin
        hdrIdxQ <= hdrIdxQ + 2'd1;
        unique case (hdrIdxQ)
          2'd0: markAQ <= inData;
          2'd1: markBQ <= inData;
          2'd2: addrQ  <= inData;
          default: sizeQ <= inData;
        endcase
      end
      if (ctrl.offAdd4)    offsetQ <= offsetQ + LEN_W'(4);
      if (ctrl.offAddSize) offsetQ <= offsetQ + LEN_W'(sizeQ);
      if (ctrl.jClr)       jQ <= '0;
      if (ctrl.jAdd4)      jQ <= jNext;
      if (ctrl.entryTake && !entrySetQ) begin
        entryQ    <= addrQ;
        entrySetQ <= 1'b1;
      end
      if (ctrl.pageFirst) pageQ <= addrQ;
      if (ctrl.pageNext)  pageQ <= addrQ + jNext;
      if (ctrl.wordLatch) wordQ <= inData;
      if (ctrl.flagErr) begin
        errQ    <= 1'b1;
        errOffQ <= offsetQ + LEN_W'(jQ);
        pageQ   <= '0;
      end
      if (ctrl.finish) begin
        pageQ   <= '0;
        doneQ   <= 1'b1;
        loadedQ <= errQ ? '0 : lenQ;
      end
    end
  end

  always_comb begin
    flags.haveRoom  = (SUM_W'(offsetQ) + SUM_W'(16)) < SUM_W'(lenQ);
    flags.syncOk    = (markAQ == MARK_A) && (markBQ == MARK_B);
    flags.overrun   = (SUM_W'(offsetQ) + SUM_W'(sizeQ)) > SUM_W'(lenQ);
    flags.sizeZero  = (sizeQ == '0);
    flags.skipDone  = (jQ >= sizeQ) || (offsetQ >= lenQ);
    flags.lastWord  = (SUM_W'(jQ) + SUM_W'(4)) >= SUM_W'(sizeQ);
    flags.nextChunk = (jNext[PAGE_W-1:0] == '0);
    flags.mismatch  = (memRdata != wordQ);
    flags.hdrLast   = (hdrIdxQ == 2'd3);
  end

  assign memWe       = ctrl.memWrite;
  assign memRe       = ctrl.memRead;
  assign memAddr     = jQ[PAGE_W-1:0];
  assign memWdata    = inData;
  assign pageSel     = pageQ;
  assign done        = doneQ;
  assign error       = errQ;
  assign errOffset   = errOffQ;
  assign entryAddr   = entryQ;
  assign loadedBytes = loadedQ;

  // R6
  readback_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (memRe && $stable(memAddr) && $stable(pageSel)));

  // R6
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));

  // R8
  page_home_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (pageQ == '0));

  // R9
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !ctrl.clrAll) |=> errQ);

  // R3
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entrySetQ && !ctrl.clrAll) |=> $stable(entryQ));

endmodule

// File: rtl/fw_seg_loader.sv
module fw_seg_loader
  import fw_seg_loader_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int PAGE_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  imageBytes,
  input  logic              inValid,
  input  logic [31:0]       inData,
  output logic              inReady,
  output logic              memWe,
  output logic              memRe,
  output logic [PAGE_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [31:0]       pageSel,
  output logic              done,
  output logic              error,
  output logic [LEN_W-1:0]  errOffset,
  output logic [31:0]       entryAddr,
  output logic [LEN_W-1:0]  loadedBytes
);

  loadCtrl_t  ctrl;
  loadFlags_t flags;

  fw_seg_loader_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .flags(flags), .inReady(inReady), .ctrl(ctrl)
  );

  fw_seg_loader_dp #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .imageBytes(imageBytes),
    .inData(inData), .memRdata(memRdata), .flags(flags),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .pageSel(pageSel), .done(done), .error(error), .errOffset(errOffset),
    .entryAddr(entryAddr), .loadedBytes(loadedBytes)
  );

endmodule

// File: tb/fw_seg_loader_tb.sv
module fw_seg_loader_tb_top;

  localparam logic [31:0] MA = 32'h6D676553;
  localparam logic [31:0] MB = 32'h72646548;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] imageBytes = '0;
  logic        inValid;
  logic [31:0] inData;
  logic        inReady, memWe, memRe, done, error;
  logic [11:0] memAddr;
  logic [31:0] memWdata, memRdata, pageSel, errOffset, entryAddr, loadedBytes;

  always #4 clk = ~clk;

  fw_seg_loader dut_i (
    .clk(clk), .rstN(rstN), .start(start), .imageBytes(imageBytes),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .pageSel(pageSel), .done(done), .error(error),
    .errOffset(errOffset), .entryAddr(entryAddr), .loadedBytes(loadedBytes)
  );

  // stream source
  logic [31:0] img [0:1099];
  int          nWords = 0;
  int          idx = 0;
  logic        stallMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  always @(posedge clk) begin
    if (start) idx <= 0;
    else if (inValid && inReady) idx <= idx + 1;
  end
  always_comb begin
    inValid = (idx < nWords) && (!stallMode || lfsr[0]);
    inData  = (idx < nWords) ? img[idx] : 32'h0;
  end

  // memory model: location = pageSel + memAddr, one-cycle read latency
  logic [31:0] mem [0:4095];
  logic [31:0] faultLoc = 32'hFFFF_FFFF;
  int          writeCount = 0;
  logic [31:0] pageLog [0:7];
  int          pageCount = 0;

  always @(posedge clk) begin
    if (memWe) begin
      mem[((pageSel + 32'(memAddr)) >> 2) & 32'hFFF] <=
        ((pageSel + 32'(memAddr)) == faultLoc) ? (memWdata ^ 32'h1) : memWdata;
      writeCount <= writeCount + 1;
      if (memAddr == 12'd0 && pageCount < 8) begin
        pageLog[pageCount] <= pageSel;
        pageCount <= pageCount + 1;
      end
    end
    if (memRe) memRdata <= mem[((pageSel + 32'(memAddr)) >> 2) & 32'hFFF];
  end

  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] loc);
    return mem[(loc >> 2) & 32'hFFF];
  endfunction

  task automatic clearAll();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) pageLog[i] = '0;
    writeCount = 0;
    pageCount  = 0;
    nWords     = 0;
    faultLoc   = 32'hFFFF_FFFF;
  endtask

  task automatic push(input logic [31:0] w);
    img[nWords] = w;
    nWords++;
  endtask

  task automatic pushHdr(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] addr, input logic [31:0] sz);
    push(a); push(b); push(addr); push(sz);
  endtask

  // start a run and wait for done; a timeout counts as a failed check
  task automatic runLoad(input logic [31:0] len, input string tag);
    int waited;
    @(negedge clk);
    imageBytes = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) check({tag, " watchdog"}, 32'(done), 32'd1);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 done", 32'(done), 0);
    check("R10 error", 32'(error), 0);
    check("R10 inReady", 32'(inReady), 0);
    check("R10 memWe/memRe", 32'({memWe, memRe}), 0);
    check("R10 pageSel", pageSel, 0);
  endtask

  task automatic testSingle();
    clearAll();
    pushHdr(MA, MB, 32'h100, 12);
    for (int k = 0; k < 3; k++) push(32'hA000_0000 + 32'(k));
    runLoad(28, "single");
    check("R1 word0", rd(32'h100), 32'hA000_0000);
    check("R1 word2", rd(32'h108), 32'hA000_0002);
    check("R1 writes", 32'(writeCount), 3);
    check("R3 entry", entryAddr, 32'h100);
    check("R5 page base", pageLog[0], 32'h100);
    check("R8 pageSel home", pageSel, 0);
    check("R8 loadedBytes", loadedBytes, 28);
    check("R8 error clear", 32'(error), 0);
  endtask

  task automatic buildSkipImage();
    clearAll();
    pushHdr(32'h1234_5678, MB, 32'h40, 8);
    push(32'hDEAD_0001); push(32'hDEAD_0002);
    pushHdr(MA, MB, 32'h200, 8);
    push(32'hB000_0000); push(32'hB000_0001);
    pushHdr(MA, MB, 32'h300, 4);
    push(32'hC000_0000);
  endtask

  task automatic checkSkipImage(input string tag);
    check({tag, " R2 skipped not written"}, rd(32'h40), 0);
    check({tag, " R2 write count"}, 32'(writeCount), 3);
    check({tag, " R1 seg A"}, rd(32'h204), 32'hB000_0001);
    check({tag, " R1 seg B"}, rd(32'h300), 32'hC000_0000);
    check({tag, " R3 first entry kept"}, entryAddr, 32'h200);
    check({tag, " R11 words consumed"}, 32'(idx), 17);
    check({tag, " R8 loadedBytes"}, loadedBytes, 68);
  endtask

  task automatic testSkip();
    buildSkipImage();
    runLoad(68, "skip");
    checkSkipImage("skip");
  endtask

  task automatic testStall();
    buildSkipImage();
    stallMode = 1'b1;
    runLoad(68, "stall");
    stallMode = 1'b0;
    checkSkipImage("stall");
  endtask

  task automatic testOverrun();
    clearAll();
    pushHdr(MA, MB, 32'h400, 64);
    push(32'hE000_0000); push(32'hE000_0001);
    runLoad(24, "overrun");
    check("R4 no writes", 32'(writeCount), 0);
    check("R4 no error", 32'(error), 0);
    check("R4 done", 32'(done), 1);
    check("R4 entry still taken", entryAddr, 32'h400);
    check("R4 stream stops after header", 32'(idx), 4);
  endtask

  task automatic testPageCross();
    clearAll();
    pushHdr(MA, MB, 32'h1000, 4104);
    for (int k = 0; k < 1026; k++) push(32'h5000_0000 + 32'(k));
    runLoad(16 + 4104, "page");
    check("R5 chunk count", 32'(pageCount), 2);
    check("R5 first page", pageLog[0], 32'h1000);
    check("R5 second page", pageLog[1], 32'h2000);
    check("R5 word after boundary", rd(32'h2000), 32'h5000_0400);
    check("R5 last word", rd(32'h2004), 32'h5000_0401);
    check("R5 word before boundary", rd(32'h1FFC), 32'h5000_03FF);
  endtask

  task automatic testMismatch();
    clearAll();
    pushHdr(MA, MB, 32'h500, 16);
    for (int k = 0; k < 4; k++) push(32'h7000_0000 + 32'(k));
    faultLoc = 32'h508;
    runLoad(32, "mismatch");
    check("R6 error", 32'(error), 1);
    check("R6 errOffset", errOffset, 24);
    check("R6 pageSel home", pageSel, 0);
    check("R6 halted writes", 32'(writeCount), 3);
    check("R8 loadedBytes on error", loadedBytes, 0);
    repeat (5) @(negedge clk);
    check("R9 error sticky", 32'(error), 1);
    check("R9 done sticky", 32'(done), 1);
  endtask

  task automatic testRestartClears();
    clearAll();
    pushHdr(MA, MB, 32'h600, 4);
    push(32'h9999_0000);
    @(negedge clk);
    imageBytes = 20;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 start clears error", 32'(error), 0);
    check("R9 start clears done", 32'(done), 0);
    while (!done) @(negedge clk);
    check("R9 rerun clean", 32'(error), 0);
    check("R1 rerun data", rd(32'h600), 32'h9999_0000);
  endtask

  task automatic testNoRoom();
    clearAll();
    pushHdr(MA, MB, 32'h700, 0);
    runLoad(16, "noroom");
    check("R7 no header parsed", 32'(idx), 0);
    check("R7 entry untouched", entryAddr, 0);
    check("R7 done", 32'(done), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testSkip();
    testStall();
    testOverrun();
    testPageCross();
    testMismatch();
    testRestartClears();
    testNoRoom();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule